// File: doc/BRIEF.md
# Serial Header Classifier

This block watches a one-bit serial packet stream and picks an output port for every packet from a short window of header bits. A small table holds the lookup entries, each made of a value, a care mask and a port number, plus an enable bit. Bits that the mask marks as care may sit anywhere in the window and need not be adjacent. A care bit that should be one is tested against the incoming data. A care bit that should be zero is tested against the inverted data. An entry matches only when neither test fails on any of its care bits. Shorter prefixes are expressed by writing extra entries with wider don't-care regions.

The stream leaves through a fixed delay line that is longer than the largest header window. The route decision is therefore ready before the packet's first bit leaves, and it is applied at the exact edge where that first bit comes out. It then holds for the whole packet. A packet that no enabled entry matches gets a clear hit flag, which sends it to the slow path. Table writes go into a staging copy, and that copy becomes live only when the next packet starts.

Top module: `hdr_steer`

## Requirements
- R1: `out_valid`, `out_sop` and `out_bit` repeat the values of `in_valid`, `in_valid & in_sop` and `in_valid & in_bit` that were sampled 47 rising edges earlier (2^OFFS_W + KEY_W - 1 with the default parameters).
- R2: The lookup key is the KEY_W bits that start `hdr_offset` bits after the start-of-packet bit, where the start-of-packet bit is position 0. `hdr_offset` is sampled only on the start-of-packet beat. The first key bit received is key bit KEY_W-1.
- R3: An entry matches when it is enabled and the key equals the entry value on every bit where the mask is 1. Bits where the mask is 0 have no effect on the result.
- R4: When several entries match, the entry with the lowest index selects the port. `rt_hit` is then 1 and `rt_port` is that entry's port.
- R5: When no entry matches, `rt_hit` is 0 and `rt_port` is 0.
- R6: `rt_hit` and `rt_port` change only at the edge where a packet's first bit appears on the outputs (`out_valid & out_sop`). They then hold that packet's decision until the next such edge.
- R7: A table write takes effect for the first packet whose start-of-packet beat is accepted on a later cycle. A packet already in progress, or one that starts in the same cycle as the write, is judged with the previous table contents.
- R8: After reset, every entry is disabled, all outputs are 0, and packets route as misses until an entry is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Serial beat valid |
| in_sop | input | 1 | Marks the first bit of a packet |
| in_bit | input | 1 | Serial data bit |
| hdr_offset | input | OFFS_W | Window start in bits after the start-of-packet bit, sampled at start of packet |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | $clog2(ENTRIES) | Entry written |
| cfg_en | input | 1 | Entry enable |
| cfg_value | input | KEY_W | Entry value |
| cfg_mask | input | KEY_W | Entry care mask, 1 = compare |
| cfg_port | input | PORT_W | Entry output port |
| out_valid | output | 1 | Delayed beat valid |
| out_sop | output | 1 | Delayed start of packet |
| out_bit | output | 1 | Delayed data bit |
| rt_hit | output | 1 | 1 = fast-path hit, 0 = slow path |
| rt_port | output | PORT_W | Selected port, 0 on a miss |

## Verification
The assertions take two things for granted. First, a packet's beats arrive back to back with `in_valid` held high. Second, every packet is at least `hdr_offset + KEY_W` bits long, so its window finishes before the next start of packet and before its own first bit leaves the delay line. The stimulus builds each packet as one unbroken run of beats whose length is the window end plus some payload. Gaps of zero or more idle cycles fall only between packets. Table writes are made either in idle cycles or on a chosen beat inside a packet, never in place of a beat.

// File: rtl/hdr_steer.sv
module hdr_steer #(
  parameter int ENTRIES = 8,
  parameter int KEY_W   = 32,
  parameter int PORT_W  = 3,
  parameter int OFFS_W  = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic                        in_sop,
  input  logic                        in_bit,
  input  logic [OFFS_W-1:0]           hdr_offset,
  input  logic                        cfg_we,
  input  logic [$clog2(ENTRIES)-1:0]  cfg_idx,
  input  logic                        cfg_en,
  input  logic [KEY_W-1:0]            cfg_value,
  input  logic [KEY_W-1:0]            cfg_mask,
  input  logic [PORT_W-1:0]           cfg_port,
  output logic                        out_valid,
  output logic                        out_sop,
  output logic                        out_bit,
  output logic                        rt_hit,
  output logic [PORT_W-1:0]           rt_port
);
  localparam int DLY    = (1 << OFFS_W) + KEY_W;
  localparam int POS_W  = $clog2(DLY) + 1;
  localparam int KIDX_W = $clog2(KEY_W);

  logic [KEY_W-1:0]  sh_val [ENTRIES];
  logic [KEY_W-1:0]  sh_msk [ENTRIES];
  logic [PORT_W-1:0] sh_prt [ENTRIES];
  logic [KEY_W-1:0]  lv_val [ENTRIES];
  logic [KEY_W-1:0]  lv_msk [ENTRIES];
  logic [PORT_W-1:0] lv_prt [ENTRIES];
  logic [ENTRIES-1:0] sh_en, lv_en;

  logic [ENTRIES-1:0] f1, f0, f1n, f0n, ok;
  logic [POS_W-1:0]   pos, cur_pos, rel;
  logic [OFFS_W-1:0]  off_q, cur_off;
  logic [KIDX_W-1:0]  kidx;
  logic               busy, pend_hit, pend_new, nhit;
  logic [PORT_W-1:0]  pend_port, nport;
  logic [DLY-1:0]     pv, ps, pb;

  wire acc_sop = in_valid & in_sop;
  wire active  = in_valid & (in_sop | busy);
  wire take    = pv[DLY-2] & ps[DLY-2];

  assign cur_pos = acc_sop ? '0 : pos;
  assign cur_off = acc_sop ? hdr_offset : off_q;
  assign rel     = cur_pos - POS_W'(cur_off);
  assign kidx    = KIDX_W'(KEY_W - 1) - rel[KIDX_W-1:0];

  wire in_win = active && (cur_pos >= POS_W'(cur_off)) && (rel < POS_W'(KEY_W));
  wire last   = in_win && (rel == POS_W'(KEY_W - 1));

  always_comb begin
    nhit  = 1'b0;
    nport = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      logic v, m, en;
      v  = acc_sop ? sh_val[e][kidx] : lv_val[e][kidx];
      m  = acc_sop ? sh_msk[e][kidx] : lv_msk[e][kidx];
      en = acc_sop ? sh_en[e] : lv_en[e];
      f1n[e] = (f1[e] & ~acc_sop) | (in_win & m & v & ~in_bit);
      f0n[e] = (f0[e] & ~acc_sop) | (in_win & m & ~v & in_bit);
      ok[e]  = en & ~f1n[e] & ~f0n[e];
    end
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (ok[e]) begin
        nhit  = 1'b1;
        nport = acc_sop ? sh_prt[e] : lv_prt[e];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_en <= '0;
      lv_en <= '0;
      for (int e = 0; e < ENTRIES; e++) begin
        sh_val[e] <= '0; sh_msk[e] <= '0; sh_prt[e] <= '0;
        lv_val[e] <= '0; lv_msk[e] <= '0; lv_prt[e] <= '0;
      end
    end else begin
      if (cfg_we) begin
        sh_en[cfg_idx]  <= cfg_en;
        sh_val[cfg_idx] <= cfg_value;
        sh_msk[cfg_idx] <= cfg_mask;
        sh_prt[cfg_idx] <= cfg_port;
      end
      if (acc_sop) begin
        lv_en <= sh_en;
        for (int e = 0; e < ENTRIES; e++) begin
          lv_val[e] <= sh_val[e]; lv_msk[e] <= sh_msk[e]; lv_prt[e] <= sh_prt[e];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos <= '0; off_q <= '0; busy <= 1'b0;
      f1 <= '0; f0 <= '0;
      pend_hit <= 1'b0; pend_port <= '0; pend_new <= 1'b0;
      rt_hit <= 1'b0; rt_port <= '0;
      pv <= '0; ps <= '0; pb <= '0;
    end else begin
      f1 <= f1n;
      f0 <= f0n;
      if (acc_sop) off_q <= hdr_offset;
      if (active) begin
        pos  <= cur_pos + POS_W'(1);
        busy <= ~last;
      end
      if (take) begin
        rt_hit   <= pend_hit;
        rt_port  <= pend_port;
        pend_new <= 1'b0;
      end
      if (last) begin
        pend_hit  <= nhit;
        pend_port <= nport;
        pend_new  <= 1'b1;
      end
      pv <= {pv[DLY-2:0], in_valid};
      ps <= {ps[DLY-2:0], acc_sop};
      pb <= {pb[DLY-2:0], in_valid & in_bit};
    end
  end

  assign out_valid = pv[DLY-1];
  assign out_sop   = ps[DLY-1];
  assign out_bit   = pb[DLY-1];

  assert_route_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_sop) |-> ($stable(rt_hit) && $stable(rt_port)));
  assert_decision_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> pend_new);
  assert_window_closed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_sop |-> !busy);
  assert_miss_port_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rt_hit |-> (rt_port == '0));
  assert_sop_has_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_sop |-> out_valid);
endmodule

// File: tb/tb_hdr_steer.sv
`timescale 1ns/1ps
module tb_hdr_steer;
  localparam int LAT = 47;
  localparam int HN  = 4096;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_sop = 0, in_bit = 0;
  logic [3:0] hdr_offset = 0;
  logic cfg_we = 0, cfg_en = 0;
  logic [2:0] cfg_idx = 0, cfg_port = 0;
  logic [31:0] cfg_value = 0, cfg_mask = 0;
  logic out_valid, out_sop, out_bit, rt_hit;
  logic [2:0] rt_port;

  hdr_steer dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_bit(in_bit),
    .hdr_offset(hdr_offset), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en),
    .cfg_value(cfg_value), .cfg_mask(cfg_mask), .cfg_port(cfg_port),
    .out_valid(out_valid), .out_sop(out_sop), .out_bit(out_bit), .rt_hit(rt_hit), .rt_port(rt_port));

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  logic hv [HN], hs [HN], hb [HN];
  logic       sh_en [8], lv_en [8];
  logic [31:0] sh_val [8], sh_msk [8], lv_val [8], lv_msk [8];
  logic [2:0] sh_prt [8], lv_prt [8];
  logic       q_hit [$];
  logic [2:0] q_port [$];
  string      q_tag [$];
  logic       cur_hit = 0;
  logic [2:0] cur_port = 0;
  string      cur_tag = "R8";
  logic       w_en;
  logic [2:0] w_idx, w_prt;
  logic [31:0] w_val, w_msk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %0h expected %0h at cycle %0d", tag, what, got, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    hv[cyc % HN] = in_valid;
    hs[cyc % HN] = in_valid & in_sop;
    hb[cyc % HN] = in_valid & in_bit;
    cyc++;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (cyc - 1 - LAT >= 0) begin
        int k;
        k = (cyc - 1 - LAT) % HN;
        chk("R1", {29'd0, out_valid, out_sop, out_bit}, {29'd0, hv[k], hs[k], hb[k]}, "delayed stream");
      end
      if (out_valid && out_sop) begin
        if (q_hit.size() == 0) chk("R6", 1, 0, "unexpected packet start");
        else begin
          cur_hit = q_hit.pop_front(); cur_port = q_port.pop_front(); cur_tag = q_tag.pop_front();
        end
        chk(cur_tag, {28'd0, rt_hit, rt_port}, {28'd0, cur_hit, cur_port}, "route at packet start");
      end else if (out_valid) begin
        chk("R6", {28'd0, rt_hit, rt_port}, {28'd0, cur_hit, cur_port}, "route held in packet");
      end
    end
  end

  function automatic logic [3:0] model_route(input logic [31:0] key);
    for (int e = 0; e < 8; e++)
      if (lv_en[e] && (((key ^ lv_val[e]) & lv_msk[e]) == 0)) return {1'b1, lv_prt[e]};
    return 4'd0;
  endfunction

  task automatic cfg_write(input int idx, input logic en, input logic [31:0] val,
                           input logic [31:0] msk, input logic [2:0] prt);
    @(negedge clk);
    in_valid = 0; in_sop = 0;
    cfg_we = 1; cfg_idx = 3'(idx); cfg_en = en; cfg_value = val; cfg_mask = msk; cfg_port = prt;
    sh_en[idx] = en; sh_val[idx] = val; sh_msk[idx] = msk; sh_prt[idx] = prt;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic send_pkt(input string tag, input int off, input logic [31:0] key,
                          input int extra, input int gap, input int wbeat);
    int len;
    logic [3:0] r;
    len = off + 32 + extra;
    for (int e = 0; e < 8; e++) begin
      lv_en[e] = sh_en[e]; lv_val[e] = sh_val[e]; lv_msk[e] = sh_msk[e]; lv_prt[e] = sh_prt[e];
    end
    r = model_route(key);
    q_hit.push_back(r[3]); q_port.push_back(r[2:0]); q_tag.push_back(tag);
    for (int p = 0; p < len; p++) begin
      @(negedge clk);
      in_valid = 1;
      in_sop = (p == 0);
      hdr_offset = (p == 0) ? 4'(off) : 4'($urandom);
      if (p >= off && p < off + 32) in_bit = key[31 - (p - off)];
      else in_bit = 1'($urandom);
      cfg_we = (p == wbeat);
      if (p == wbeat) begin
        cfg_idx = w_idx; cfg_en = w_en; cfg_value = w_val; cfg_mask = w_msk; cfg_port = w_prt;
        sh_en[w_idx] = w_en; sh_val[w_idx] = w_val; sh_msk[w_idx] = w_msk; sh_prt[w_idx] = w_prt;
      end
    end
    if (gap > 0) begin
      @(negedge clk);
      in_valid = 0; in_sop = 0; cfg_we = 0;
      repeat (gap - 1) @(negedge clk);
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int e = 0; e < 8; e++) begin
      sh_en[e] = 0; sh_val[e] = 0; sh_msk[e] = 0; sh_prt[e] = 0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R8", {28'd0, out_valid, out_sop, rt_hit, rt_port != 0}, 32'd0, "reset outputs");

    // R8: empty table routes to slow path
    send_pkt("R8", 0, 32'hFFFF_FFFF, 3, 2, -1);
    send_pkt("R8", 5, 32'h0, 0, 0, -1);

    // R3: every single care position, both polarities
    for (int b = 0; b < 32; b++) begin
      logic [31:0] v, k;
      v = $urandom; k = $urandom;
      cfg_write(0, 1, v, 32'd1 << b, 3'(b));
      k[b] = v[b];
      send_pkt("R3", b % 16, k, b % 5, 1 + b % 3, -1);
      k[b] = ~v[b];
      send_pkt("R3", (b * 7) % 16, k, 2, 1, -1);
    end

    // R3: scattered masks of 5 to 8 care bits, matching and near-miss keys
    for (int t = 0; t < 40; t++) begin
      logic [31:0] v, m, k;
      int nb;
      m = 0; nb = 5 + t % 4;
      while ($countones(m) < nb) m[$urandom % 32] = 1'b1;
      v = $urandom;
      cfg_write(t % 8, 1, v, m, 3'($urandom));
      k = (v & m) | ($urandom & ~m);
      if (t % 3 == 2) k = k ^ (m & (32'd1 << ($urandom % 32)));
      send_pkt("R3", $urandom % 16, k, t % 7, t % 3, -1);
    end

    // R4: all entries wildcard, disable from the bottom upward
    for (int e = 0; e < 8; e++) cfg_write(e, 1, 0, 0, 3'(7 - e));
    for (int i = 0; i < 8; i++) begin
      send_pkt("R4", i, $urandom, 1, 1, -1);
      cfg_write(i, 0, 0, 0, 0);
    end
    send_pkt("R5", 3, $urandom, 0, 1, -1);

    // R2: exact-key entry, offset swept, offset input scrambled after start
    cfg_write(0, 1, 32'hA5C3_0F96, 32'hFFFF_FFFF, 3'd5);
    for (int o = 0; o < 16; o++) begin
      send_pkt("R2", o, 32'hA5C3_0F96, o % 4, o % 2, -1);
      send_pkt("R2", o, 32'hA5C3_0F96 ^ (32'd1 << (o * 2)), 0, 0, -1);
    end

    // R7: write during a packet affects only the following packet
    cfg_write(0, 1, 32'h1234_5678, 32'hFFFF_FFFF, 3'd2);
    w_idx = 0; w_en = 1; w_val = 32'h1234_5678; w_msk = 32'hFFFF_FFFF; w_prt = 3'd6;
    send_pkt("R7", 4, 32'h1234_5678, 4, 0, 10);
    send_pkt("R7", 4, 32'h1234_5678, 4, 2, -1);
    w_idx = 1; w_en = 1; w_val = 0; w_msk = 0; w_prt = 3'd3;
    send_pkt("R7", 0, 32'h0BAD_CAFE, 2, 0, 1);
    send_pkt("R7", 0, 32'h0BAD_CAFE, 2, 1, -1);
    cfg_write(1, 0, 0, 0, 0);

    // R4/R5: random tables, keys drawn near entries
    for (int t = 0; t < 150; t++) begin
      logic [31:0] k;
      int e;
      if (t % 10 == 0)
        for (int x = 0; x < 8; x++)
          cfg_write(x, 1'($urandom % 4 != 0), $urandom, $urandom & $urandom, 3'($urandom));
      e = $urandom % 8;
      k = (sh_val[e] & sh_msk[e]) | ($urandom & ~sh_msk[e]);
      if (t % 4 == 3) k = $urandom;
      send_pkt(t % 4 == 3 ? "R5" : "R4", $urandom % 16, k, $urandom % 12, $urandom % 3, -1);
    end

    @(negedge clk);
    in_valid = 0; in_sop = 0; cfg_we = 0;
    repeat (LAT + 10) @(negedge clk);
    chk("R6", q_hit.size(), 0, "decisions left undelivered");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule